// File: doc/BRIEF.md
# LIN Response Checksum and Receive Overflow Checker

This block sits behind a LIN byte receiver and handles the response part of a frame. Each received byte arrives as a one-cycle `byteValid` pulse with its data. Bytes that carry data go into a single holding register, `rxData`, and raise `dataReady`. Software or a DMA channel empties the register with `rdStrobe`. If a new data byte arrives while the register still holds an unread byte, the new byte is discarded, the held byte stays as it is, and a sticky overflow flag is raised.

When checking is enabled, the byte flagged with `byteLast` is taken as the frame's checksum. The block forms a running 8-bit sum of the frame with the carry folded back in, inverts it, and compares the result with that byte. A mismatch raises a sticky checksum error flag. There are two modes:

- **Classic:** sums only the data bytes.
- **Enhanced:** also adds the protected identifier as the first term.

The running sum restarts after every frame.

Top module: `lin_rx_check`

## Requirements
- R1: After reset, `rxData` is 0 and `dataReady`, `chkErr` and `ovflErr` are all low.
- R2: A data byte arriving while `dataReady` is low appears on `rxData`, with `dataReady` high, on the cycle after its `byteValid` pulse. A data byte is any valid byte except a last byte with checking enabled.
- R3: A data byte arriving while `dataReady` is high and `rdStrobe` is low sets `ovflErr` on the next cycle. In that case `rxData` keeps its old value and `dataReady` stays high.
- R4: `rdStrobe` clears `dataReady` on the next cycle. If `rdStrobe` and a data byte come in the same cycle, the new byte is loaded, `dataReady` stays high and no overflow is flagged.
- R5: With `chkEnable` low, the last byte is treated as a data byte and `chkErr` never gets set.
- R6: With `chkEnable` high, the last byte is not stored and does not change `dataReady`. `chkErr` is set on the next cycle if that byte differs from the bitwise inverse of the frame sum.
- R7: The frame sum is an 8-bit add with the carry-out added back in. With `chkEnhanced` low (classic) it starts from 0. With `chkEnhanced` high (enhanced) it starts from `protId`. Mode and identifier are sampled on the first byte of each frame.
- R8: The first valid byte after reset, or after any byte with `byteLast` high, starts a new frame sum.
- R9: `chkErr` and `ovflErr` stay set until their clear strobe (`clrChkErr` or `clrOvfl`) is high for a cycle. A clear in the same cycle as a new error event leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| byteValid | input | 1 | One-cycle pulse marking a received byte |
| byteData | input | 8 | Received byte value |
| byteLast | input | 1 | Marks the final byte of the frame |
| protId | input | 8 | Protected identifier of the current frame |
| chkEnable | input | 1 | Treat the last byte as a checksum and check it |
| chkEnhanced | input | 1 | 1 = enhanced sum including the identifier, 0 = classic |
| rdStrobe | input | 1 | Read of the receive register by CPU or DMA |
| clrChkErr | input | 1 | Write-one-to-clear for `chkErr` |
| clrOvfl | input | 1 | Write-one-to-clear for `ovflErr` |
| rxData | output | 8 | Held received data byte |
| dataReady | output | 1 | Unread data present in `rxData` |
| chkErr | output | 1 | Sticky checksum mismatch flag |
| ovflErr | output | 1 | Sticky receive overflow flag |

## Verification
The assertions assume the following about the inputs:
- `byteLast` only has meaning together with `byteValid`.
- `protId` and the mode bit are valid on the first byte of a frame.
- No frame boundary falls anywhere other than on a byte flagged last.

The stimulus drives every input on the falling clock edge and raises `byteLast` only on a byte pulse. It keeps `protId` and the mode stable for the whole of each frame, so the reference model never needs to decide which cycle the mode was sampled in.

// File: rtl/lin_rx_pkg.sv
package lin_rx_pkg;
  typedef struct packed {
    logic frameStart;  // the current byte is the first of a frame
    logic sumLoad;     // store the updated running sum
    logic dataLoad;    // write the byte into the receive register
  } ctrlStrb_t;
endpackage

// File: rtl/lin_rx_dpath.sv
module lin_rx_dpath
  import lin_rx_pkg::*;
#(
  parameter int DataW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrb_t        strb,
  input  logic [DataW-1:0] byteData,
  input  logic [DataW-1:0] protId,
  input  logic             chkEnhanced,
  output logic [DataW-1:0] rxData,
  output logic             sumMismatch
);
  localparam int WideW = DataW + 1;

  logic [DataW-1:0] sumReg;
  logic [DataW-1:0] sumBase;
  logic [WideW-1:0] sumWide;
  logic [DataW-1:0] sumNext;

  always_comb begin
    if (strb.frameStart) sumBase = chkEnhanced ? protId : '0;
    else                 sumBase = sumReg;
    sumWide     = {1'b0, sumBase} + {1'b0, byteData};
    sumNext     = sumWide[DataW-1:0] + {{(DataW-1){1'b0}}, sumWide[DataW]};
    sumMismatch = (byteData != ~sumBase);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumReg <= '0;
      rxData <= '0;
    end else begin
      if (strb.sumLoad)  sumReg <= sumNext;
      if (strb.dataLoad) rxData <= byteData;
    end
  end

  // R2: a loaded byte shows on the register output one cycle later
  assert_load_visible_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.dataLoad |=> rxData == $past(byteData));
endmodule

// File: rtl/lin_rx_ctrl.sv
module lin_rx_ctrl
  import lin_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      byteValid,
  input  logic      byteLast,
  input  logic      chkEnable,
  input  logic      rdStrobe,
  input  logic      clrChkErr,
  input  logic      clrOvfl,
  input  logic      sumMismatch,
  output ctrlStrb_t strb,
  output logic      dataReady,
  output logic      chkErr,
  output logic      ovflErr
);
  logic startPend;
  logic isChkByte;
  logic isDataByte;

  always_comb begin
    isChkByte     = byteValid & byteLast & chkEnable;
    isDataByte    = byteValid & ~isChkByte;
    strb.frameStart = startPend;
    strb.sumLoad    = isDataByte;
    strb.dataLoad   = isDataByte & (~dataReady | rdStrobe);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startPend <= 1'b1;
      dataReady <= 1'b0;
      chkErr    <= 1'b0;
      ovflErr   <= 1'b0;
    end else begin
      if (byteValid) startPend <= byteLast;
      if (strb.dataLoad)  dataReady <= 1'b1;
      else if (rdStrobe)  dataReady <= 1'b0;
      chkErr  <= (chkErr & ~clrChkErr) | (isChkByte & sumMismatch);
      ovflErr <= (ovflErr & ~clrOvfl) | (isDataByte & dataReady & ~rdStrobe);
    end
  end

  // R9: flags hold without a clear strobe
  assert_chk_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (chkErr && !clrChkErr) |=> chkErr);
  assert_ovfl_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ovflErr && !clrOvfl) |=> ovflErr);
  // R5: checking disabled never raises the checksum flag
  assert_no_chk_when_off_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!chkEnable && !chkErr) |=> !chkErr);
  // R4: a lone read empties the register
  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && !byteValid) |=> !dataReady);
endmodule

// File: rtl/lin_rx_check.sv
module lin_rx_check
  import lin_rx_pkg::*;
#(
  parameter int DataW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             byteValid,
  input  logic [DataW-1:0] byteData,
  input  logic             byteLast,
  input  logic [DataW-1:0] protId,
  input  logic             chkEnable,
  input  logic             chkEnhanced,
  input  logic             rdStrobe,
  input  logic             clrChkErr,
  input  logic             clrOvfl,
  output logic [DataW-1:0] rxData,
  output logic             dataReady,
  output logic             chkErr,
  output logic             ovflErr
);
  ctrlStrb_t strb;
  logic      sumMismatch;

  lin_rx_ctrl ctrlInst (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteLast(byteLast),
    .chkEnable(chkEnable), .rdStrobe(rdStrobe), .clrChkErr(clrChkErr),
    .clrOvfl(clrOvfl), .sumMismatch(sumMismatch), .strb(strb),
    .dataReady(dataReady), .chkErr(chkErr), .ovflErr(ovflErr)
  );

  lin_rx_dpath #(.DataW(DataW)) dpathInst (
    .clk(clk), .rstN(rstN), .strb(strb), .byteData(byteData),
    .protId(protId), .chkEnhanced(chkEnhanced), .rxData(rxData),
    .sumMismatch(sumMismatch)
  );

  // R3: an overflowing byte keeps the held data and raises the flag
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && !(byteLast && chkEnable) && dataReady && !rdStrobe)
      |=> (ovflErr && dataReady && $stable(rxData)));
  // R6: a checksum byte never touches the receive register
  assert_chk_byte_not_stored_R6: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && byteLast && chkEnable && !rdStrobe)
      |=> ($stable(rxData) && $stable(dataReady)));
endmodule

// File: tb/lin_rx_check_test.sv
module lin_rx_check_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       byteValid = 1'b0, byteLast = 1'b0;
  logic [7:0] byteData = '0, protId = '0;
  logic       chkEnable = 1'b0, chkEnhanced = 1'b0;
  logic       rdStrobe = 1'b0, clrChkErr = 1'b0, clrOvfl = 1'b0;
  logic [7:0] rxData;
  logic       dataReady, chkErr, ovflErr;

  always #2.5 clk = ~clk;  // 200 MHz

  lin_rx_check uut (.*);

  int    checks = 0, errors = 0;
  string curReq = "R1";
  bit    finished = 0;

  // reference model state (value after the coming clock edge)
  int mData = 0, mSum = 0;
  bit mReady = 0, mChk = 0, mOvf = 0, mStart = 1;

  task automatic checkOne(string name, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", curReq, name, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    checkOne("rxData", rxData, mData);
    checkOne("dataReady", dataReady, mReady);
    checkOne("chkErr", chkErr, mChk);
    checkOne("ovflErr", ovflErr, mOvf);
  endtask

  task automatic step(bit bv, int bd, bit last, bit rd, bit cc, bit co);
    int  base, s;
    bit  isChk, nC, nO;
    @(negedge clk);
    compareAll();
    byteValid = bv; byteData = bd[7:0]; byteLast = last;
    rdStrobe = rd; clrChkErr = cc; clrOvfl = co;
    isChk = bv && last && chkEnable;
    base  = mStart ? (chkEnhanced ? int'(protId) : 0) : mSum;
    nC = mChk && !cc;
    nO = mOvf && !co;
    if (bv && isChk) begin
      if (bd != ((~base) & 255)) nC = 1;
    end else if (bv) begin
      s = base + bd;
      if (s > 255) s = s - 256 + 1;
      mSum = s;
      if (mReady && !rd) nO = 1;
      else begin mData = bd; mReady = 1; end
    end
    if (rd && !(bv && !isChk)) mReady = 0;
    if (bv) mStart = last;
    mChk = nC; mOvf = nO;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  // correct checksum over a list of bytes, optionally including the identifier
  function automatic int goodSum(int q[$], bit enh, int pid);
    int s = enh ? pid : 0;
    foreach (q[i]) begin
      s += q[i];
      if (s > 255) s = s - 256 + 1;
    end
    return (~s) & 255;
  endfunction

  task automatic sendFrame(int q[$], int ck, bit withChk);
    foreach (q[i]) step(1, q[i], !withChk && (i == q.size() - 1), 1, 0, 0);
    if (withChk) step(1, ck, 1, 1, 0, 0);
    step(0, 0, 0, 1, 0, 0);
  endtask

  initial begin
    int q[$];
    #1;
    curReq = "R1";
    compareAll();
    #20 rstN = 1'b1;
    idle(2);

    curReq = "R2"; step(1, 8'h5A, 0, 0, 0, 0); idle(1);
    curReq = "R3"; step(1, 8'hC3, 0, 0, 0, 0); idle(2);
    curReq = "R4"; step(0, 0, 0, 1, 0, 0); idle(1);
    step(1, 8'h11, 0, 0, 0, 0); step(1, 8'h22, 0, 1, 0, 0); idle(1);
    curReq = "R9"; step(1, 8'h33, 0, 0, 0, 1); idle(1);
    step(0, 0, 0, 0, 0, 1); idle(1);
    step(0, 0, 0, 1, 0, 0); mStart = 1;

    curReq = "R5"; chkEnable = 0;
    q = '{8'h01, 8'h02, 8'h77}; sendFrame(q, 0, 0); idle(1);

    curReq = "R7"; chkEnable = 1; chkEnhanced = 0; protId = 8'hA6;
    q = '{8'hF0, 8'h20, 8'h35}; sendFrame(q, goodSum(q, 0, 8'hA6), 1); idle(1);
    chkEnhanced = 1; protId = 8'h97;
    q = '{8'hFF, 8'h81}; sendFrame(q, goodSum(q, 1, 8'h97), 1); idle(1);

    curReq = "R6";
    sendFrame(q, goodSum(q, 0, 8'h97), 1); idle(2);
    step(0, 0, 0, 0, 1, 0); idle(1);
    step(1, 8'h44, 0, 0, 0, 0); step(1, 8'h00, 1, 0, 0, 0); idle(1);
    step(0, 0, 0, 1, 1, 1);

    curReq = "R8";
    q = '{8'h10}; sendFrame(q, goodSum(q, 1, 8'h97), 1);
    q = '{8'hE0, 8'h30}; sendFrame(q, goodSum(q, 1, 8'h97), 1); idle(1);
    chkEnhanced = 0;
    q = '{}; sendFrame(q, 8'hFF, 1); idle(1);
    sendFrame(q, 8'h12, 1); idle(2);

    curReq = "R9"; step(1, 8'h5E, 1, 0, 1, 0); idle(2);
    idle(3);
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule